// File: doc/BRIEF.md
# Shaped On-Off Keying Amplitude Ramp

This block scales a 14-bit unsigned sine sample by a 14-bit amplitude factor so that a transmit burst fades in and out along a controlled slope rather than switching in a single step. The scaled result is the upper 14 bits of the 28-bit product. With the block disabled, the sample passes through untouched.

Two sources can supply the factor. In manual mode a held copy of the programmed scale word is used; that copy is refreshed only on the update strobe. In automatic mode a saturating counter supplies it. The counter climbs toward a programmed ceiling while the keying input is high and falls toward zero while it is low. It moves by 1, 2, 4 or 8 each time an 8-bit ramp-rate timer expires. A control input can also make the update strobe restart the timer period.

Top module: `osk_ramp`

## Requirements
- R1: With `enable_i` low, `sample_o` equals `sample_i` in the same cycle, whatever the scale source holds.
- R2: In manual mode (`auto_i` low), the held scale loads `scale_reg_i` at each clock edge where `update_i` is high. A change of `scale_reg_i` without the strobe leaves `scale_o` and `sample_o` unchanged.
- R3: With `enable_i` high, `sample_o` = (`sample_i` × `scale_o`) >> 14, with both operands treated as unsigned.
- R4: In automatic mode (`enable_i` and `auto_i` high), each timer expiry raises the counter while `key_i` is high and lowers it while `key_i` is low. `scale_o` shows the counter.
- R5: The counter never wraps. Rising stops at `ceiling_i`. Falling stops at zero.
- R6: The step per expiry is 1 << `step_sel_i`. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8.
- R7: After entering automatic mode with `rate_i` = N (N ≥ 1), the first step lands on the N-th clock edge and later steps land every N edges. A `rate_i` of 0 behaves as 1.
- R8: With `reload_on_update_i` low, `update_i` does not disturb the timer. With it high, `update_i` restarts the N-edge period. A strobe on an expiry edge still lets that step happen.
- R9: Outside automatic mode, the counter holds its value and the timer does not run, so `rate_i` has no effect.
- R10: Reset clears the counter and the held manual scale to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 14 | Unsigned sine sample |
| enable_i | input | 1 | Scaling enable; low bypasses |
| auto_i | input | 1 | 1 = ramp counter source, 0 = held manual scale |
| key_i | input | 1 | Ramp direction in automatic mode (1 up, 0 down) |
| update_i | input | 1 | Update strobe, one clock wide |
| reload_on_update_i | input | 1 | Strobe also restarts the ramp timer |
| step_sel_i | input | 2 | Step size code |
| rate_i | input | 8 | Ramp timer period in clocks |
| ceiling_i | input | 14 | Top of the automatic ramp |
| scale_reg_i | input | 14 | Manual scale word |
| sample_o | output | 14 | Scaled or bypassed sample |
| scale_o | output | 14 | Scale factor picked by `auto_i` |

## Verification
The timer's own expiry and the strobe-driven reload can land on the same edge. The bench provokes this with a 2-clock period and places the strobe on the expiry edge. It judges the result by seeing the step taken on that edge, then no step on the next edge, then a step on the edge after that. It also steps with size 8 into the ceiling and into zero from values that are not multiples of 8, so that saturation and stepping fall together.

// File: rtl/osk_pkg.sv
package osk_pkg;
  localparam int unsigned STEP_SEL_W = 2;

  typedef enum logic [1:0] {
    SRC_BYPASS = 2'd0,
    SRC_MANUAL = 2'd1,
    SRC_AUTO   = 2'd2
  } scale_src_e;

  function automatic scale_src_e pick_src(input logic en, input logic auto_mode);
    if (!en)       return SRC_BYPASS;
    if (auto_mode) return SRC_AUTO;
    return SRC_MANUAL;
  endfunction
endpackage

// File: rtl/osk_rate_timer.sv
module osk_rate_timer #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  // 0 and 1 both expire at once
  assign tick_o = run_i && (cnt_q <= RATE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i)                cnt_q <= rate_i;
    else if (tick_o || restart_i)   cnt_q <= rate_i;
    else                            cnt_q <= cnt_q - RATE_W'(1);
  end
endmodule

// File: rtl/osk_ramp_counter.sv
module osk_ramp_counter #(
  parameter int unsigned SCALE_W    = 14,
  parameter int unsigned STEP_SEL_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  up_i,
  input  logic [STEP_SEL_W-1:0] step_sel_i,
  input  logic [SCALE_W-1:0]    ceiling_i,
  output logic [SCALE_W-1:0]    cnt_o
);
  localparam int unsigned SUM_W = SCALE_W + 1;

  logic [SCALE_W-1:0] cnt_q, cnt_d, step;
  logic [SUM_W-1:0]   sum;

  assign step = SCALE_W'(1) << step_sel_i;
  assign sum  = {1'b0, cnt_q} + {1'b0, step};

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      if (up_i) cnt_d = (sum > {1'b0, ceiling_i}) ? ceiling_i : sum[SCALE_W-1:0];
      else      cnt_d = (cnt_q > step) ? cnt_q - step : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/osk_scale_mult.sv
module osk_scale_mult #(
  parameter int unsigned DATA_W  = 14,
  parameter int unsigned SCALE_W = 14
) (
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               bypass_i,
  output logic [DATA_W-1:0]  sample_o
);
  localparam int unsigned PROD_W = DATA_W + SCALE_W;

  logic [PROD_W-1:0] prod;

  assign prod     = {{SCALE_W{1'b0}}, sample_i} * {{DATA_W{1'b0}}, scale_i};
  assign sample_o = bypass_i ? sample_i : prod[PROD_W-1 -: DATA_W];
endmodule

// File: rtl/osk_ramp.sv
module osk_ramp
  import osk_pkg::*;
#(
  parameter int unsigned DATA_W  = 14,
  parameter int unsigned SCALE_W = 14,
  parameter int unsigned RATE_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DATA_W-1:0]     sample_i,
  input  logic                  enable_i,
  input  logic                  auto_i,
  input  logic                  key_i,
  input  logic                  update_i,
  input  logic                  reload_on_update_i,
  input  logic [STEP_SEL_W-1:0] step_sel_i,
  input  logic [RATE_W-1:0]     rate_i,
  input  logic [SCALE_W-1:0]    ceiling_i,
  input  logic [SCALE_W-1:0]    scale_reg_i,
  output logic [DATA_W-1:0]     sample_o,
  output logic [SCALE_W-1:0]    scale_o
);
  scale_src_e         src;
  logic               ramp_active, tick;
  logic [SCALE_W-1:0] ramp_cnt, manual_scale;

  assign src         = pick_src(enable_i, auto_i);
  assign ramp_active = (src == SRC_AUTO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       manual_scale <= '0;
    else if (update_i) manual_scale <= scale_reg_i;
  end

  osk_rate_timer #(.RATE_W(RATE_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ramp_active),
    .restart_i (update_i && reload_on_update_i),
    .rate_i    (rate_i),
    .tick_o    (tick)
  );

  osk_ramp_counter #(.SCALE_W(SCALE_W), .STEP_SEL_W(STEP_SEL_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .up_i       (key_i),
    .step_sel_i (step_sel_i),
    .ceiling_i  (ceiling_i),
    .cnt_o      (ramp_cnt)
  );

  assign scale_o = auto_i ? ramp_cnt : manual_scale;

  osk_scale_mult #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_mult (
    .sample_i (sample_i),
    .scale_i  (scale_o),
    .bypass_i (src == SRC_BYPASS),
    .sample_o (sample_o)
  );
endmodule

// File: rtl/osk_ramp_chk.sv
module osk_ramp_chk #(
  parameter int unsigned DATA_W  = 14,
  parameter int unsigned SCALE_W = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               enable_i,
  input logic               key_i,
  input logic               update_i,
  input logic               active_i,
  input logic [DATA_W-1:0]  sample_i,
  input logic [DATA_W-1:0]  sample_o,
  input logic [SCALE_W-1:0] ceiling_i,
  input logic [SCALE_W-1:0] cnt_i,
  input logic [SCALE_W-1:0] manual_i
);
  // R1
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> sample_o == sample_i);

  // R2
  manual_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(manual_i));

  // R4
  ramp_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && key_i && cnt_i <= ceiling_i) |=> (cnt_i >= $past(cnt_i)) || !$stable(ceiling_i));

  // R4
  ramp_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !key_i) |=> cnt_i <= $past(cnt_i));

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i <= ceiling_i) |=> (cnt_i <= ceiling_i) || !$stable(ceiling_i));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(cnt_i));
endmodule

bind osk_ramp osk_ramp_chk #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .key_i     (key_i),
  .update_i  (update_i),
  .active_i  (ramp_active),
  .sample_i  (sample_i),
  .sample_o  (sample_o),
  .ceiling_i (ceiling_i),
  .cnt_i     (ramp_cnt),
  .manual_i  (manual_scale)
);

// File: tb/sim_osk_ramp.sv
module sim_osk_ramp;
  localparam int CLK_P = 10;
  localparam int NVEC  = 8;
  // {enable, sample, manual scale}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b1, 14'h3FFF, 14'h2000},
    {1'b1, 14'h3FFF, 14'h3FFF},
    {1'b1, 14'h1234, 14'h0000},
    {1'b1, 14'h2AAA, 14'h1000},
    {1'b1, 14'h0001, 14'h3FFF},
    {1'b0, 14'h3FFF, 14'h0001},
    {1'b1, 14'h0ABC, 14'h0800},
    {1'b0, 14'h1555, 14'h2ABC}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [13:0] sample_i = 14'h1234, ceiling_i = 14'd20, scale_reg_i = '0;
  logic        enable_i = 0, auto_i = 0, key_i = 0, update_i = 0, reload_on_update_i = 0;
  logic [1:0]  step_sel_i = '0;
  logic [7:0]  rate_i = 8'd1;
  logic [13:0] sample_o, scale_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  osk_ramp u0 (.*);

  function automatic int scaled(int s, int k);
    return (s * k) >> 14;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic strobe();
    update_i = 1'b1; run(1); update_i = 1'b0;
  endtask

  task automatic finish_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_sim();
  end

  initial begin
    run(2);
    check("R10 reset scale", scale_o, 0);
    check("R1 bypass in reset", sample_o, 'h1234);
    rst_ni = 1'b1; run(1);
    enable_i = 1'b1;
    #1 check("R10 manual cleared", sample_o, 0);

    for (int i = 0; i < NVEC; i++) begin
      enable_i = VEC[i][28]; sample_i = VEC[i][27:14]; scale_reg_i = VEC[i][13:0];
      strobe();
      check("R2 manual load", scale_o, VEC[i][13:0]);
      if (VEC[i][28]) check("R3 product", sample_o, scaled(VEC[i][27:14], VEC[i][13:0]));
      else            check("R1 bypass", sample_o, VEC[i][27:14]);
    end

    enable_i = 1'b1; scale_reg_i = 14'h0001; run(3);
    check("R2 no strobe", scale_o, 'h2ABC);
    check("R2 no strobe out", sample_o, scaled('h1555, 'h2ABC));

    // automatic ramp, period 1
    sample_i = 14'h3FFF; key_i = 1; auto_i = 1; run(5);
    check("R4 up by 1", scale_o, 5);
    check("R3 auto product", sample_o, scaled('h3FFF, 5));
    step_sel_i = 2'd3; run(1);
    check("R6 step 8", scale_o, 13);
    run(1); check("R5 clamp ceiling", scale_o, 20);
    run(2); check("R5 hold ceiling", scale_o, 20);
    key_i = 0; run(2); check("R4 down", scale_o, 4);
    run(1); check("R5 clamp zero", scale_o, 0);
    run(2); check("R5 hold zero", scale_o, 0);
    key_i = 1; step_sel_i = 2'd1; run(1); check("R6 step 2", scale_o, 2);
    step_sel_i = 2'd2; run(1); check("R6 step 4", scale_o, 6);

    // idle modes ignore rate
    step_sel_i = 2'd0; auto_i = 0; rate_i = 8'd4; run(10);
    check("R9 manual shows held", scale_o, 'h2ABC);
    enable_i = 0; auto_i = 1; run(10);
    check("R9 disabled holds", scale_o, 6);

    // period 4
    enable_i = 1; run(3); check("R7 before expiry", scale_o, 6);
    run(1); check("R7 first step", scale_o, 7);
    run(3); check("R7 between", scale_o, 7);
    run(1); check("R7 second step", scale_o, 8);

    // strobe without reload
    auto_i = 0; run(1); auto_i = 1;
    run(2); strobe(); run(1);
    check("R8 strobe ignored", scale_o, 9);
    // strobe with reload
    reload_on_update_i = 1; auto_i = 0; run(1); auto_i = 1;
    run(2); strobe(); run(3);
    check("R8 restarted", scale_o, 9);
    run(1); check("R8 after restart", scale_o, 10);
    // strobe on expiry edge, period 2
    rate_i = 8'd2; auto_i = 0; run(1); auto_i = 1;
    run(1); check("R8 pre expiry", scale_o, 10);
    strobe(); check("R8 coincident step", scale_o, 11);
    run(1); check("R8 coincident gap", scale_o, 11);
    run(1); check("R8 coincident next", scale_o, 12);

    rate_i = 8'd0; auto_i = 0; run(1); auto_i = 1; run(3);
    check("R7 rate zero", scale_o, 15);

    rst_ni = 0; #1;
    check("R10 async reset", scale_o, 0);
    finish_sim();
  end
endmodule